// File: doc/BRIEF.md
# Unsigned Multiply/Divide Unit

A sequential arithmetic unit for a register-based processor datapath. It multiplies or divides two unsigned operands in one of two sizes. In byte mode the operands are 8 bits wide. In word mode they are 16 bits wide. The result is twice the operand width and is laid out for a single register-file write.

For a divide, the quotient goes in the lower half of the result and the remainder in the upper half. The unit also returns the destination register index. This is the index of the double-width register that holds the first operand's register, so it is the first operand's index with its low bits cleared.

A start pulse is accepted while the unit is idle. `busy_o` covers the run and `done_o` pulses for one cycle with the result. A zero divisor ends the operation early with the overflow flag set and the other flags marked not valid.

Top module: `mul_div_unit`

## Requirements
- R1: Byte multiply (`op_div_i`=0, `size_word_i`=0) returns the 16-bit unsigned product of the low operand bytes in `result_o[15:0]`, and `result_o[31:16]` is zero.
- R2: Word multiply (`op_div_i`=0, `size_word_i`=1) returns the 32-bit unsigned product in `result_o[31:0]`.
- R3: Byte divide (`op_div_i`=1, `size_word_i`=0) with a nonzero divisor returns the quotient in `result_o[7:0]` and the remainder in `result_o[15:8]`, and `result_o[31:16]` is zero.
- R4: Word divide (`op_div_i`=1, `size_word_i`=1) with a nonzero divisor returns the quotient in `result_o[15:0]` and the remainder in `result_o[31:16]`.
- R5: `dest_idx_o` is `reg_idx_i` with bit 0 cleared in byte mode, and with bits 1:0 cleared in word mode.
- R6: On the accepting edge, `busy_o` rises. For a normal operation with N operand bits (8 or 16), `done_o` is high for exactly one cycle, starting at the (N+1)-th rising edge after the accepting edge. In that same cycle `busy_o` is low.
- R7: A divide whose active-size divisor is zero raises `done_o` at the first rising edge after the accepting edge. It sets `ovf_o`=1 and `flags_valid_o`=0, and forces the result to all ones over the active width: 0x0000FFFF in byte mode and 0xFFFFFFFF in word mode.
- R8: Every other operation completes with `ovf_o`=0 and `flags_valid_o`=1.
- R9: `start_i` is ignored while `busy_o` is high. Operands, mode and register index are captured on the accepting edge, so later changes to the inputs do not alter the running operation.
- R10: `result_o`, `dest_idx_o`, `ovf_o` and `flags_valid_o` change only on the edge that raises `done_o`. They hold their values until the next completion.
- R11: In byte mode, bits 15:8 of both operand inputs are ignored, including when the unit detects a zero divisor.
- R12: After reset, `busy_o`, `done_o`, `ovf_o` and `flags_valid_o` are 0, and `result_o` and `dest_idx_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request an operation; accepted when not busy |
| op_div_i | input | 1 | 0 = multiply, 1 = divide |
| size_word_i | input | 1 | 0 = byte operands, 1 = word operands |
| opa_i | input | 16 | First operand (multiplicand or dividend) |
| opb_i | input | 16 | Second operand (multiplier or divisor) |
| reg_idx_i | input | 5 | Register index of the first operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Packed product, or remainder:quotient |
| dest_idx_o | output | 5 | Aligned destination register index |
| ovf_o | output | 1 | Set on a zero divisor |
| flags_valid_o | output | 1 | Low when the other status is meaningless |

## Verification
The byte sweep drives every first operand against divisors 0, 1, 2, 255 and multiples of 17, with junk in the upper operand bytes. A design that reads the upper byte in byte mode would miss zero divisors or produce wrong products. A design that swaps quotient and remainder, or misaligns the byte lanes, shows up on every divide.

Word corners combine 0, 1, 0x8000 and 0xFFFF with random vectors. These expose a lost carry in the shift-add sum and a lost top trial bit in the restoring subtract.

Latency is counted edge by edge, which catches an off-by-one step count or a zero-divisor divide that still runs the full loop. A separate run holds start high with new operands while busy; a unit that re-accepts would return the second result.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WRAP = 2'd2
  } mdu_state_e;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } mdu_op_e;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } mdu_size_e;

  typedef struct packed {
    mdu_op_e   op;
    mdu_size_e size;
    logic      zdiv;
  } mdu_cmd_t;
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int unsigned BYTE_STEPS = 8,
  parameter int unsigned WORD_STEPS = 16,
  parameter int unsigned CNT_W      = $clog2(WORD_STEPS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic size_word_i,
  input  logic zero_div_i,
  output logic accept_o,
  output logic step_o,
  output logic capture_o,
  output logic busy_o
);
  mdu_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;

  assign accept_o  = start_i && (state_q == ST_IDLE);
  assign step_o    = (state_q == ST_RUN);
  assign capture_o = (state_q == ST_WRAP);
  assign busy_o    = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      last_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          cnt_q   <= '0;
          last_q  <= size_word_i ? CNT_W'(WORD_STEPS - 1) : CNT_W'(BYTE_STEPS - 1);
          // zero divisor skips the iteration loop
          state_q <= zero_div_i ? ST_WRAP : ST_RUN;
        end
        ST_RUN: begin
          if (cnt_q == last_q) state_q <= ST_WRAP;
          else                 cnt_q   <= cnt_q + 1'b1;
        end
        ST_WRAP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdu_mul_seq.sv
module mdu_mul_seq #(
  parameter int unsigned W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] acc_q;
  logic [PW-1:0] mcand_q;
  logic [W-1:0]  mplier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (load_i) begin
      acc_q    <= '0;
      mcand_q  <= {{W{1'b0}}, a_i};
      mplier_q <= b_i;
    end else if (step_i) begin
      acc_q    <= acc_q + (mplier_q[0] ? mcand_q : '0);
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
    end
  end

  assign prod_o = acc_q;
endmodule

// File: rtl/mdu_div_seq.sv
module mdu_div_seq #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dvd_i,  // MSB-aligned to the active size
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] rem_q;
  logic [W-1:0] quo_q;
  logic [W-1:0] dvs_q;
  logic [W:0]   trial;
  logic [W:0]   diff;
  logic         fits;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = (trial >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      quo_q <= dvd_i;
      dvs_q <= dvs_i;
    end else if (step_i) begin
      rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/mul_div_unit.sv
module mul_div_unit
  import mdu_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                op_div_i,
  input  logic                size_word_i,
  input  logic [WORD_W-1:0]   opa_i,
  input  logic [WORD_W-1:0]   opb_i,
  input  logic [IDX_W-1:0]    reg_idx_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [2*WORD_W-1:0] result_o,
  output logic [IDX_W-1:0]    dest_idx_o,
  output logic                ovf_o,
  output logic                flags_valid_o
);
  localparam int unsigned RES_W   = 2 * WORD_W;
  localparam int unsigned BRES_W  = 2 * BYTE_W;
  localparam int unsigned LANE_SH = WORD_W - BYTE_W;

  logic [WORD_W-1:0] a_eff, b_eff, dvd_aln;
  logic              zero_div;
  logic              accept, step, capture;
  mdu_cmd_t          cmd_q;
  logic [IDX_W-1:0]  dest_pend_q;
  logic [IDX_W-1:0]  dest_next;
  logic [RES_W-1:0]  prod;
  logic [WORD_W-1:0] quo, rem;
  logic [RES_W-1:0]  res_next;
  logic [RES_W-1:0]  res_q;
  logic [IDX_W-1:0]  dest_q;
  logic              ovf_q, fv_q, done_q;

  // byte lanes: upper operand bits are dropped in byte mode
  generate
    if (LANE_SH > 0) begin : g_lane_mask
      always_comb begin
        a_eff = size_word_i ? opa_i : {{LANE_SH{1'b0}}, opa_i[BYTE_W-1:0]};
        b_eff = size_word_i ? opb_i : {{LANE_SH{1'b0}}, opb_i[BYTE_W-1:0]};
      end
    end else begin : g_lane_pass
      always_comb begin
        a_eff = opa_i;
        b_eff = opb_i;
      end
    end
  endgenerate

  always_comb begin
    dvd_aln  = size_word_i ? a_eff : (a_eff << LANE_SH);
    zero_div = op_div_i && (b_eff == '0);
    // containing register: byte reg -> word reg, word reg -> dword reg
    dest_next = size_word_i ? {reg_idx_i[IDX_W-1:2], 2'b00}
                            : {reg_idx_i[IDX_W-1:1], 1'b0};
  end

  mdu_ctrl #(
    .BYTE_STEPS(BYTE_W),
    .WORD_STEPS(WORD_W),
    .CNT_W     ($clog2(WORD_W))
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .size_word_i(size_word_i),
    .zero_div_i (zero_div),
    .accept_o   (accept),
    .step_o     (step),
    .capture_o  (capture),
    .busy_o     (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q       <= '{op: OP_MUL, size: SZ_BYTE, zdiv: 1'b0};
      dest_pend_q <= '0;
    end else if (accept) begin
      cmd_q.op    <= mdu_op_e'(op_div_i);
      cmd_q.size  <= mdu_size_e'(size_word_i);
      cmd_q.zdiv  <= zero_div;
      dest_pend_q <= dest_next;
    end
  end

  mdu_mul_seq #(.W(WORD_W)) u_mul (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept && !op_div_i),
    .step_i(step && (cmd_q.op == OP_MUL)),
    .a_i   (a_eff),
    .b_i   (b_eff),
    .prod_o(prod)
  );

  mdu_div_seq #(.W(WORD_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept && op_div_i),
    .step_i(step && (cmd_q.op == OP_DIV)),
    .dvd_i (dvd_aln),
    .dvs_i (b_eff),
    .quo_o (quo),
    .rem_o (rem)
  );

  always_comb begin
    res_next = '0;
    if (cmd_q.zdiv) begin
      res_next = (cmd_q.size == SZ_WORD) ? '1 : RES_W'({BRES_W{1'b1}});
    end else if (cmd_q.op == OP_MUL) begin
      res_next = (cmd_q.size == SZ_WORD) ? prod : RES_W'(prod[BRES_W-1:0]);
    end else if (cmd_q.size == SZ_WORD) begin
      res_next = {rem, quo};
    end else begin
      res_next = RES_W'({rem[BYTE_W-1:0], quo[BYTE_W-1:0]});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      dest_q <= '0;
      ovf_q  <= 1'b0;
      fv_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= capture;
      if (capture) begin
        res_q  <= res_next;
        dest_q <= dest_pend_q;
        ovf_q  <= cmd_q.zdiv;
        fv_q   <= !cmd_q.zdiv;
      end
    end
  end

  assign done_o        = done_q;
  assign result_o      = res_q;
  assign dest_idx_o    = dest_q;
  assign ovf_o         = ovf_q;
  assign flags_valid_o = fv_q;
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned IDX_W  = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                busy_o,
  input logic                done_o,
  input logic [2*WORD_W-1:0] result_o,
  input logic [IDX_W-1:0]    dest_idx_o,
  input logic                ovf_o,
  input logic                flags_valid_o
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o) && !busy_o); // R6
  AST_ZDIV_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ovf_o) |-> (!flags_valid_o && (result_o[2*BYTE_W-1:0] == {2*BYTE_W{1'b1}}))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && flags_valid_o) |-> !ovf_o); // R8
  AST_DEST_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !dest_idx_o[0]); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(dest_idx_o) && $stable(ovf_o))); // R10
endmodule

bind mul_div_unit mdu_checker #(
  .BYTE_W(BYTE_W),
  .WORD_W(WORD_W),
  .IDX_W (IDX_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .result_o     (result_o),
  .dest_idx_o   (dest_idx_o),
  .ovf_o        (ovf_o),
  .flags_valid_o(flags_valid_o)
);

// File: tb/test_mul_div_unit.sv
`timescale 1ns/1ps
module test_mul_div_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_div = 1'b0;
  logic        size_word = 1'b0;
  logic [15:0] opa = '0;
  logic [15:0] opb = '0;
  logic [4:0]  idx = '0;
  logic        busy, done, ovf, fv;
  logic [31:0] result;
  logic [4:0]  dest;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mul_div_unit i_mul_div_unit (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .op_div_i     (op_div),
    .size_word_i  (size_word),
    .opa_i        (opa),
    .opb_i        (opb),
    .reg_idx_i    (idx),
    .busy_o       (busy),
    .done_o       (done),
    .result_o     (result),
    .dest_idx_o   (dest),
    .ovf_o        (ovf),
    .flags_valid_o(fv)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input bit dv, input bit sz, input logic [15:0] a, input logic [15:0] b,
                       input logic [4:0] ri);
    logic [31:0] am, bm, er, r;
    logic [4:0]  ed, d;
    logic        o, f;
    bit          eo, seq_ok;
    int          el, lat;
    string       tag;
    am = sz ? {16'h0, a} : {24'h0, a[7:0]};
    bm = sz ? {16'h0, b} : {24'h0, b[7:0]};
    eo = dv && (bm == 0);
    if (!dv) begin
      er  = am * bm;
      tag = sz ? "R2" : "R1 R11";
    end else if (eo) begin
      er  = sz ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      tag = "R7 R11";
    end else begin
      er  = sz ? (((am % bm) << 16) | (am / bm)) : (((am % bm) << 8) | (am / bm));
      tag = sz ? "R4" : "R3 R11";
    end
    // done seen at negedge index (edges after accept + 1)
    el = eo ? 2 : (sz ? 18 : 10);
    ed = sz ? {ri[4:2], 2'b00} : {ri[4:1], 1'b0};

    @(negedge clk);
    op_div = dv; size_word = sz; opa = a; opb = b; idx = ri; start = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    seq_ok = busy;
    lat    = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    r = result; d = dest; o = ovf; f = fv;
    @(negedge clk);
    seq_ok = seq_ok && !done && !busy;

    chk(r == er, tag, r, er);
    chk((o == eo) && (f == !eo), eo ? "R7 flags" : "R8 flags", 32'({o, f}), 32'({eo, !eo}));
    chk(d == ed, "R5 dest", 32'(d), 32'(ed));
    chk((lat == el) && seq_ok, "R6 latency", 32'(lat), 32'(el));
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r0;
    logic [4:0]  d0;
    logic [15:0] wc [4];
    bit          held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !ovf && !fv && result == 0 && dest == 0, "R12 reset",
        {busy, done, ovf, fv, result[27:0]}, 32'h0);

    // byte sweep, upper operand bytes carry junk (R11)
    for (int a = 0; a < 256; a++) begin
      for (int j = 0; j < 19; j++) begin
        logic [7:0] bb;
        logic [7:0] junk;
        bb   = (j < 16) ? 8'(j * 17) : 8'(j - 15);
        junk = 8'(a) ^ 8'hA5;
        do_op(1'b0, 1'b0, {junk, 8'(a)}, {~junk, bb}, 5'(a ^ j));
        do_op(1'b1, 1'b0, {junk, 8'(a)}, {~junk, bb}, 5'(a + j));
      end
    end

    // word corners
    wc[0] = 16'h0000; wc[1] = 16'h0001; wc[2] = 16'h8000; wc[3] = 16'hFFFF;
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 4; k++) begin
        do_op(1'b0, 1'b1, wc[i], wc[k], 5'(i * 4 + k + 3));
        do_op(1'b1, 1'b1, wc[i], wc[k], 5'(i * 4 + k + 17));
      end
    end

    // word random
    for (int n = 0; n < 150; n++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = (n % 5 == 0) ? 16'($urandom % 8) : 16'($urandom);
      do_op(1'b0, 1'b1, ra, rb, 5'($urandom));
      do_op(1'b1, 1'b1, ra, rb, 5'($urandom));
    end

    // R9: start held high with new operands while busy
    @(negedge clk);
    op_div = 1'b0; size_word = 1'b1; opa = 16'd1234; opb = 16'd5678; idx = 5'd9; start = 1'b1;
    @(negedge clk);
    op_div = 1'b1; opa = 16'd7; opb = 16'd0; idx = 5'd31;
    held = busy;
    repeat (4) begin
      @(negedge clk);
      held = held && busy && !done;
    end
    start = 1'b0;
    for (int w = 0; w < 40 && !done; w++) @(negedge clk);
    chk(held && done && result == 32'd7006652 && dest == 5'd8 && !ovf, "R9 start ignored",
        result, 32'd7006652);

    // R10: outputs hold after completion while inputs move
    r0 = result; d0 = dest;
    held = 1'b1;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      opa = 16'(t * 991); opb = 16'(t); idx = 5'(t + 1); op_div = t[0];
      held = held && !done && result == r0 && dest == d0 && !ovf && fv;
    end
    chk(held, "R10 hold", result, r0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule